// File: doc/BRIEF.md
# Operand Address Sequencer

This unit sits beside an 8-bit processor's instruction decoder. Once an opcode has been fetched, the decoder pulses `start` with the addressing mode, the access class (read, write or read-modify-write), the address of the first operand byte and the two index registers. The unit then fetches the operand bytes and any page-zero pointer through a synchronous read port, and forms the effective address. It also issues the dummy bus reads the processor is known to make, and reports how many cycles the instruction takes beyond its base count.

The read port is registered. A byte requested with `mem_rd` high in one cycle is presented on `mem_rdata` in the next cycle. When the sequence ends, `done` is high for a single cycle, and `ea`, `pc_out` and `extra_cyc` are valid in that cycle. Those three outputs keep their values until the next request. Executing the instruction and decoding the opcode are left to the surrounding logic.

Mode codes on `mode` are: 0 immediate, 1 zero page, 2 zero page + X, 3 zero page + Y, 4 absolute, 5 absolute + X, 6 absolute + Y, 7 indexed indirect (X), 8 indirect indexed (Y), 9 relative branch. Access class codes on `acc` are: 0 read, 1 write, 2 read-modify-write.

Top module: `eag_top`

## Requirements
- R1: While `rst_n` is low, `done`, `busy`, `mem_rd`, `ea`, `extra_cyc` and `pc_out` are all zero, and `mem_rd` is never high unless `busy` is high.
- R2: Absolute mode (4) reads the operand bytes at `pc_in` and then at `pc_in`+1, low byte first. It gives `ea` = {second byte, first byte} and `pc_out` = `pc_in`+2.
- R3: The zero-page modes (1, 2, 3) read one operand byte at `pc_in`. They add 0, X or Y to it modulo 256, so `ea[15:8]` is 0. They give `pc_out` = `pc_in`+1.
- R4: Indexed indirect mode (7) forms the pointer p = (operand + X) mod 256. It reads the low byte at p and the high byte at (p+1) mod 256, both in page zero. The pointer value is `ea`, and no penalty is reported.
- R5: Indirect indexed mode (8) reads a pointer at the operand byte o and at (o+1) mod 256, both in page zero. It gives `ea` = pointer + Y.
- R6: For a read (`acc`=0) in modes 5, 6 or 8, an index sum that changes address bit 8 gives `extra_cyc`=1. It also causes one dummy read at {base high byte, sum low byte}. Without that change, `extra_cyc` is 0 and no dummy read is made.
- R7: For a write or read-modify-write (`acc`=1 or 2) in modes 5, 6 or 8, a dummy read at {base high byte, sum low byte} is always made, and `extra_cyc` is 0.
- R8: Relative mode (9) reads a signed 8-bit displacement d at `pc_in`, and the target is `pc_in`+1+d. When taken, `pc_out` and `ea` are the target, and `extra_cyc` is 1, or 2 if the target's high byte differs from that of `pc_in`+1. When not taken, `pc_out` = `pc_in`+1 and `extra_cyc` = 0.
- R9: `done` is high for exactly one cycle per request, and `busy` is low in the cycle after it. A `start` pulse that arrives while `busy` is high is ignored.
- R10: Immediate mode (0) makes no memory read. It gives `ea` = `pc_in`, `pc_out` = `pc_in`+1 and `extra_cyc` = 0.
- R11: Address sums wrap modulo 65536. A dummy read keeps the un-carried base high byte even when the sum wraps past 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (sampled only while idle) |
| mode | input | 4 | Addressing mode code |
| acc | input | 2 | Access class code |
| taken | input | 1 | Branch condition result, for relative mode |
| pc_in | input | 16 | Address of the first operand byte |
| x_in | input | 8 | X index |
| y_in | input | 8 | Y index |
| mem_addr | output | 16 | Read port address |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, one cycle after the strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Effective address |
| pc_out | output | 16 | Program counter after the operand |
| extra_cyc | output | 2 | Extra cycles beyond the base count |

## Verification
Indexed modes are driven with index values that land just below a page boundary and just past it. Each is repeated for the read, write and read-modify-write classes, which separates the conditional penalty from the unconditional dummy read, and the recorded read addresses show whether the dummy address kept the un-carried high byte. Pointer operands of 0xFE and 0xFF with small X values expose any carry out of page zero. Branches are run forward and backward, within a page and across one, and once not taken, so that the 0/1/2 penalty cases and the sign extension of the displacement are each seen on their own.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int MODE_W = 4;
  localparam int ACC_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    AM_IMM = 4'd0, AM_ZP  = 4'd1, AM_ZPX = 4'd2, AM_ZPY = 4'd3,
    AM_ABS = 4'd4, AM_ABX = 4'd5, AM_ABY = 4'd6, AM_IZX = 4'd7,
    AM_IZY = 4'd8, AM_REL = 4'd9
  } amode_t;

  typedef enum logic [ACC_W-1:0] {
    AC_READ = 2'd0, AC_WRITE = 2'd1, AC_RMW = 2'd2
  } aclass_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPLO, ST_OPHI, ST_ABCAP, ST_ZPCALC, ST_PLO,
    ST_PHI, ST_PCAP, ST_INDEX, ST_RELCALC, ST_FIN
  } seq_t;
endpackage

// File: rtl/eag_zp_unit.sv
module eag_zp_unit #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] offset,
  output logic [DW-1:0] sum,
  output logic [DW-1:0] sum_next
);
  function automatic logic [DW-1:0] page_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  always_comb begin
    sum      = page_add(base, offset);
    sum_next = page_add(sum, DW'(1));
  end
endmodule

// File: rtl/eag_idx_unit.sv
module eag_idx_unit #(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] idx,
  output logic [AW-1:0] sum,
  output logic          crossed,
  output logic [AW-1:0] dummy_addr
);
  function automatic logic [AW-1:0] wide_add(input logic [AW-1:0] a, input logic [DW-1:0] b);
    return a + {{(AW-DW){1'b0}}, b};
  endfunction

  always_comb begin
    sum        = wide_add(base, idx);
    crossed    = sum[DW] ^ base[DW];
    dummy_addr = {base[AW-1:DW], sum[DW-1:0]};
  end
endmodule

// File: rtl/eag_rel_unit.sv
module eag_rel_unit #(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic [AW-1:0] pc_next,
  input  logic [DW-1:0] disp,
  input  logic          taken,
  output logic [AW-1:0] target,
  output logic [1:0]    extra
);
  function automatic logic [AW-1:0] branch_dest(input logic [AW-1:0] p, input logic [DW-1:0] d);
    return p + {{(AW-DW){d[DW-1]}}, d};
  endfunction

  always_comb begin
    target = branch_dest(pc_next, disp);
    if (!taken)
      extra = 2'd0;
    else if (target[AW-1:DW] != pc_next[AW-1:DW])
      extra = 2'd2;
    else
      extra = 2'd1;
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [MODE_W-1:0]   mode,
  input  logic [ACC_W-1:0]    acc,
  input  logic                taken,
  input  logic [ADDR_W-1:0]   pc_in,
  input  logic [DATA_W-1:0]   x_in,
  input  logic [DATA_W-1:0]   y_in,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rd,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                busy,
  output logic                done,
  output logic [ADDR_W-1:0]   ea,
  output logic [ADDR_W-1:0]   pc_out,
  output logic [1:0]          extra_cyc
);
  localparam logic [ADDR_W-DATA_W-1:0] PAGE0 = '0;

  seq_t                state;
  amode_t              mode_r;
  aclass_t             acc_r;
  logic                taken_r;
  logic [ADDR_W-1:0]   pc_r;
  logic [DATA_W-1:0]   x_r, y_r, lo_r, ptr_r, ptr_nx_r;
  logic [ADDR_W-1:0]   base_r, ea_r;
  logic [1:0]          extra_r;

  // named internal events for the checker
  logic                idx_cross_w;
  logic                in_index_w;
  logic [ADDR_W-1:0]   idx_sum_w, idx_dummy_w;
  logic [DATA_W-1:0]   zp_off_w, zp_sum_w, zp_next_w;
  logic [DATA_W-1:0]   idx_val_w;
  logic [ADDR_W-1:0]   rel_tgt_w;
  logic [1:0]          rel_extra_w;
  logic                is_abs_w, is_zp_w;

  always_comb begin
    is_abs_w = (mode_r == AM_ABS) || (mode_r == AM_ABX) || (mode_r == AM_ABY);
    is_zp_w  = (mode_r == AM_ZP) || (mode_r == AM_ZPX) || (mode_r == AM_ZPY);
    if ((mode_r == AM_ZPX) || (mode_r == AM_IZX))
      zp_off_w = x_r;
    else if (mode_r == AM_ZPY)
      zp_off_w = y_r;
    else
      zp_off_w = '0;
    idx_val_w  = ((mode_r == AM_ABY) || (mode_r == AM_IZY)) ? y_r : x_r;
    in_index_w = (state == ST_INDEX);
  end

  eag_zp_unit #(.DW(DATA_W)) u_zp (
    .base(mem_rdata), .offset(zp_off_w), .sum(zp_sum_w), .sum_next(zp_next_w)
  );

  eag_idx_unit #(.DW(DATA_W), .AW(ADDR_W)) u_idx (
    .base(base_r), .idx(idx_val_w), .sum(idx_sum_w),
    .crossed(idx_cross_w), .dummy_addr(idx_dummy_w)
  );

  eag_rel_unit #(.DW(DATA_W), .AW(ADDR_W)) u_rel (
    .pc_next(pc_r), .disp(mem_rdata), .taken(taken_r),
    .target(rel_tgt_w), .extra(rel_extra_w)
  );

  // read port
  always_comb begin
    mem_rd   = 1'b0;
    mem_addr = '0;
    unique case (state)
      ST_OPLO, ST_OPHI: begin
        mem_rd   = 1'b1;
        mem_addr = pc_r;
      end
      ST_PLO: begin
        mem_rd   = 1'b1;
        mem_addr = {PAGE0, ptr_r};
      end
      ST_PHI: begin
        mem_rd   = 1'b1;
        mem_addr = {PAGE0, ptr_nx_r};
      end
      ST_INDEX: begin
        mem_rd   = (acc_r != AC_READ) || idx_cross_w;
        mem_addr = mem_rd ? idx_dummy_w : '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mode_r   <= AM_IMM;
      acc_r    <= AC_READ;
      taken_r  <= 1'b0;
      pc_r     <= '0;
      x_r      <= '0;
      y_r      <= '0;
      lo_r     <= '0;
      ptr_r    <= '0;
      ptr_nx_r <= '0;
      base_r   <= '0;
      ea_r     <= '0;
      extra_r  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          mode_r  <= amode_t'(mode);
          acc_r   <= aclass_t'(acc);
          taken_r <= taken;
          x_r     <= x_in;
          y_r     <= y_in;
          extra_r <= '0;
          if (amode_t'(mode) == AM_IMM) begin
            ea_r  <= pc_in;
            pc_r  <= pc_in + ADDR_W'(1);
            state <= ST_FIN;
          end else begin
            pc_r  <= pc_in;
            state <= ST_OPLO;
          end
        end
        ST_OPLO: begin
          pc_r <= pc_r + ADDR_W'(1);
          if (is_abs_w)
            state <= ST_OPHI;
          else if (mode_r == AM_REL)
            state <= ST_RELCALC;
          else
            state <= ST_ZPCALC;
        end
        ST_OPHI: begin
          lo_r  <= mem_rdata;
          pc_r  <= pc_r + ADDR_W'(1);
          state <= ST_ABCAP;
        end
        ST_ABCAP: begin
          base_r <= {mem_rdata, lo_r};
          if (mode_r == AM_ABS) begin
            ea_r  <= {mem_rdata, lo_r};
            state <= ST_FIN;
          end else begin
            state <= ST_INDEX;
          end
        end
        ST_ZPCALC: begin
          ptr_r    <= zp_sum_w;
          ptr_nx_r <= zp_next_w;
          if (is_zp_w) begin
            ea_r  <= {PAGE0, zp_sum_w};
            state <= ST_FIN;
          end else begin
            state <= ST_PLO;
          end
        end
        ST_PLO: state <= ST_PHI;
        ST_PHI: begin
          lo_r  <= mem_rdata;
          state <= ST_PCAP;
        end
        ST_PCAP: begin
          base_r <= {mem_rdata, lo_r};
          if (mode_r == AM_IZX) begin
            ea_r  <= {mem_rdata, lo_r};
            state <= ST_FIN;
          end else begin
            state <= ST_INDEX;
          end
        end
        ST_INDEX: begin
          ea_r    <= idx_sum_w;
          extra_r <= ((acc_r == AC_READ) && idx_cross_w) ? 2'd1 : 2'd0;
          state   <= ST_FIN;
        end
        ST_RELCALC: begin
          ea_r    <= rel_tgt_w;
          extra_r <= rel_extra_w;
          if (taken_r) pc_r <= rel_tgt_w;
          state   <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);
  assign ea        = ea_r;
  assign pc_out    = pc_r;
  assign extra_cyc = extra_r;
endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          busy,
  input logic          mem_rd,
  input logic [AW-1:0] ea,
  input logic [1:0]    extra_cyc,
  input logic [3:0]    cur_mode,
  input logic [1:0]    cur_acc,
  input logic          ev_cross,
  input logic          in_index
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  // R1
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |-> busy);
  // R10
  imm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_mode == 4'd0) |-> !mem_rd);
  // R3
  zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cur_mode >= 4'd1 && cur_mode <= 4'd3) |-> (ea[AW-1:AW/2] == '0));
  // R7
  wr_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cur_acc != 2'd0 && (cur_mode == 4'd5 || cur_mode == 4'd6 || cur_mode == 4'd8))
      |-> extra_cyc == 2'd0);
  // R7
  wr_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_index && cur_acc != 2'd0) |-> mem_rd);
  // R6
  rd_penalty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_index && cur_acc == 2'd0 && ev_cross) |=> (done && extra_cyc == 2'd1));
  // R8
  extra_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> extra_cyc != 2'd3);
endmodule

bind eag_top eag_chk #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .busy(busy), .mem_rd(mem_rd),
  .ea(ea), .extra_cyc(extra_cyc), .cur_mode(mode_r), .cur_acc(acc_r),
  .ev_cross(idx_cross_w), .in_index(in_index_w)
);

// File: tb/sim_eag_top.sv
module sim_eag_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  acc = '0;
  logic        taken = 1'b0;
  logic [15:0] pc_in = '0;
  logic [7:0]  x_in = '0, y_in = '0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata = '0;
  logic        busy, done;
  logic [15:0] ea, pc_out;
  logic [1:0]  extra_cyc;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eag_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .acc(acc), .taken(taken),
    .pc_in(pc_in), .x_in(x_in), .y_in(y_in), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .ea(ea), .pc_out(pc_out),
    .extra_cyc(extra_cyc)
  );

  // sparse memory image
  logic [15:0] ov_a [8];
  logic [7:0]  ov_d [8];
  int          ov_n = 0;
  logic [15:0] rd_log [16];
  int          rd_n = 0;
  logic [7:0]  pend_d = '0;
  int          done_cnt = 0;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    logic [7:0] v = a[7:0] ^ a[15:8] ^ 8'h5A;
    for (int i = 0; i < ov_n; i++) if (ov_a[i] == a) v = ov_d[i];
    return v;
  endfunction

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    ov_a[ov_n] = a; ov_d[ov_n] = d; ov_n++;
  endtask

  always @(negedge clk) if (mem_rd) begin
    if (rd_n < 16) rd_log[rd_n] = mem_addr;
    rd_n++;
    pend_d = mem_byte(mem_addr);
  end
  always @(posedge clk) mem_rdata <= pend_d;
  always @(posedge clk) if (done) done_cnt++;

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic [15:0] r_ea, r_pc;
  logic [1:0]  r_ex;

  task automatic run_op(input logic [3:0] m, input logic [1:0] a, input logic [15:0] pc,
                        input logic [7:0] xv, input logic [7:0] yv, input logic tk,
                        input logic intrude);
    int d0;
    int k;
    rd_n = 0;
    d0 = done_cnt;
    @(negedge clk);
    start = 1'b1; mode = m; acc = a; pc_in = pc; x_in = xv; y_in = yv; taken = tk;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      @(negedge clk);
      start = 1'b1; mode = 4'd0; pc_in = 16'h7777;
      @(negedge clk);
      start = 1'b0;
    end
    k = 0;
    while (!done && k < 40) begin @(negedge clk); k++; end
    checks++;
    if (!done) begin
      errors++;
      $display("FAIL R9 done never seen: actual 0 expected 1");
    end
    r_ea = ea; r_pc = pc_out; r_ex = extra_cyc;
    repeat (4) @(negedge clk);
    check("R9", "done count per request", 16'(done_cnt - d0), 16'd1);
    check("R9", "busy after done", {15'd0, busy}, 16'd0);
  endtask

  task automatic t_reset;
    check("R1", "done in reset", {15'd0, done}, 16'd0);
    check("R1", "busy in reset", {15'd0, busy}, 16'd0);
    check("R1", "mem_rd in reset", {15'd0, mem_rd}, 16'd0);
    check("R1", "ea in reset", ea, 16'd0);
    check("R1", "pc_out in reset", pc_out, 16'd0);
    check("R1", "extra in reset", {14'd0, extra_cyc}, 16'd0);
  endtask

  task automatic t_imm;
    run_op(4'd0, 2'd0, 16'h1234, 8'h00, 8'h00, 1'b0, 1'b0);
    check("R10", "imm ea", r_ea, 16'h1234);
    check("R10", "imm pc", r_pc, 16'h1235);
    check("R10", "imm extra", {14'd0, r_ex}, 16'd0);
    check("R10", "imm reads", 16'(rd_n), 16'd0);
  endtask

  task automatic t_zp;
    ov_n = 0; poke(16'h0200, 8'h80);
    run_op(4'd1, 2'd0, 16'h0200, 8'h90, 8'h05, 1'b0, 1'b0);
    check("R3", "zp ea", r_ea, 16'h0080);
    check("R3", "zp pc", r_pc, 16'h0201);
    run_op(4'd2, 2'd0, 16'h0200, 8'h90, 8'h05, 1'b0, 1'b0);
    check("R3", "zpx wrap ea", r_ea, 16'h0010);
    run_op(4'd3, 2'd1, 16'h0200, 8'h90, 8'h05, 1'b0, 1'b0);
    check("R3", "zpy ea", r_ea, 16'h0085);
    check("R3", "zpy single read", 16'(rd_n), 16'd1);
  endtask

  task automatic t_abs;
    ov_n = 0; poke(16'h0300, 8'h34); poke(16'h0301, 8'h12);
    run_op(4'd4, 2'd0, 16'h0300, 8'h00, 8'h00, 1'b0, 1'b0);
    check("R2", "abs ea", r_ea, 16'h1234);
    check("R2", "abs pc", r_pc, 16'h0302);
    check("R2", "abs read count", 16'(rd_n), 16'd2);
    check("R2", "abs first read", rd_log[0], 16'h0300);
    check("R2", "abs second read", rd_log[1], 16'h0301);
  endtask

  task automatic t_absidx;
    ov_n = 0; poke(16'h0300, 8'hF0); poke(16'h0301, 8'h12);
    run_op(4'd5, 2'd0, 16'h0300, 8'h0F, 8'h00, 1'b0, 1'b0);
    check("R6", "abx read no-cross ea", r_ea, 16'h12FF);
    check("R6", "abx read no-cross extra", {14'd0, r_ex}, 16'd0);
    check("R6", "abx read no-cross reads", 16'(rd_n), 16'd2);
    run_op(4'd5, 2'd0, 16'h0300, 8'h10, 8'h00, 1'b0, 1'b0);
    check("R6", "abx read cross ea", r_ea, 16'h1300);
    check("R6", "abx read cross extra", {14'd0, r_ex}, 16'd1);
    check("R6", "abx read cross reads", 16'(rd_n), 16'd3);
    check("R6", "abx read cross dummy", rd_log[2], 16'h1200);
    run_op(4'd6, 2'd1, 16'h0300, 8'h00, 8'h01, 1'b0, 1'b0);
    check("R7", "aby write ea", r_ea, 16'h12F1);
    check("R7", "aby write extra", {14'd0, r_ex}, 16'd0);
    check("R7", "aby write dummy", rd_log[2], 16'h12F1);
    run_op(4'd6, 2'd2, 16'h0300, 8'h00, 8'h20, 1'b0, 1'b0);
    check("R7", "aby rmw ea", r_ea, 16'h1310);
    check("R7", "aby rmw extra", {14'd0, r_ex}, 16'd0);
    check("R7", "aby rmw dummy", rd_log[2], 16'h1210);
    ov_n = 0; poke(16'h0300, 8'hF0); poke(16'h0301, 8'hFF);
    run_op(4'd6, 2'd0, 16'h0300, 8'h00, 8'h20, 1'b0, 1'b0);
    check("R11", "wrap ea", r_ea, 16'h0010);
    check("R11", "wrap extra", {14'd0, r_ex}, 16'd1);
    check("R11", "wrap dummy", rd_log[2], 16'hFF10);
  endtask

  task automatic t_izx;
    ov_n = 0; poke(16'h0400, 8'hFE); poke(16'h00FF, 8'h78); poke(16'h0000, 8'h56);
    run_op(4'd7, 2'd0, 16'h0400, 8'h01, 8'h00, 1'b0, 1'b0);
    check("R4", "izx ea", r_ea, 16'h5678);
    check("R4", "izx pc", r_pc, 16'h0401);
    check("R4", "izx lo ptr read", rd_log[1], 16'h00FF);
    check("R4", "izx hi ptr read wraps", rd_log[2], 16'h0000);
    check("R4", "izx extra", {14'd0, r_ex}, 16'd0);
  endtask

  task automatic t_izy;
    ov_n = 0; poke(16'h0400, 8'hFF); poke(16'h00FF, 8'hF0); poke(16'h0000, 8'h40);
    run_op(4'd8, 2'd0, 16'h0400, 8'h33, 8'h20, 1'b0, 1'b0);
    check("R5", "izy read ea", r_ea, 16'h4110);
    check("R5", "izy hi ptr read wraps", rd_log[2], 16'h0000);
    check("R6", "izy read cross extra", {14'd0, r_ex}, 16'd1);
    check("R6", "izy read cross dummy", rd_log[3], 16'h4010);
    run_op(4'd8, 2'd1, 16'h0400, 8'h33, 8'h01, 1'b0, 1'b0);
    check("R5", "izy write ea", r_ea, 16'h40F1);
    check("R7", "izy write dummy", rd_log[3], 16'h40F1);
    check("R7", "izy write extra", {14'd0, r_ex}, 16'd0);
  endtask

  task automatic t_rel;
    ov_n = 0; poke(16'h0410, 8'h05); poke(16'h04F0, 8'h20);
    run_op(4'd9, 2'd0, 16'h0410, 8'h00, 8'h00, 1'b1, 1'b0);
    check("R8", "fwd same page pc", r_pc, 16'h0416);
    check("R8", "fwd same page extra", {14'd0, r_ex}, 16'd1);
    run_op(4'd9, 2'd0, 16'h04F0, 8'h00, 8'h00, 1'b1, 1'b0);
    check("R8", "fwd cross pc", r_pc, 16'h0511);
    check("R8", "fwd cross extra", {14'd0, r_ex}, 16'd2);
    ov_n = 0; poke(16'h0410, 8'h80);
    run_op(4'd9, 2'd0, 16'h0410, 8'h00, 8'h00, 1'b1, 1'b0);
    check("R8", "back cross pc", r_pc, 16'h0391);
    check("R8", "back cross extra", {14'd0, r_ex}, 16'd2);
    run_op(4'd9, 2'd0, 16'h0410, 8'h00, 8'h00, 1'b0, 1'b0);
    check("R8", "not taken pc", r_pc, 16'h0411);
    check("R8", "not taken extra", {14'd0, r_ex}, 16'd0);
  endtask

  task automatic t_busy_start;
    ov_n = 0; poke(16'h0300, 8'h34); poke(16'h0301, 8'h12);
    run_op(4'd4, 2'd0, 16'h0300, 8'h00, 8'h00, 1'b0, 1'b1);
    check("R9", "start while busy ignored ea", r_ea, 16'h1234);
    check("R9", "start while busy ignored pc", r_pc, 16'h0302);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_imm();
    t_zp();
    t_abs();
    t_absidx();
    t_izx();
    t_izy();
    t_rel();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule